// File: doc/BRIEF.md
# Timer Core with Software Event Generation

This block is a 16-bit general-purpose timer. It has a programmable prescaler and a counter that counts up, down or up-and-down (centre-aligned). It also holds an auto-reload limit with an optional shadow copy, four capture/compare channels and a status word. Software uses a simple register port to configure it and to read its state. Software can also write a one-shot command word that forces the same events the timer raises on its own: an update, a channel event, or a trigger.

A forced update restarts the count and its prescaler phase and loads the pending limit and prescaler values into their working copies. A forced channel event does one of two things, depending on the channel's mode. In input mode it captures the counter, and flags an overcapture if the previous capture was not yet acknowledged. In output mode it only raises the channel flag. Each flag can raise the shared interrupt line if software enables it. Each event can also send a one-cycle DMA request pulse on its own line if software enables it.

Top module: `tmr_evgen_core`

Register map (word address on `addr`):

| Addr | Name | Content |
|---|---|---|
| 0 | CTRL | bit 0 run, bits 2:1 mode (0 up, 1 down, 2 or 3 centre), bit 3 limit shadow enable |
| 1 | IEN | bits 0 / 4:1 / 6 interrupt enable for update / channels 1 to 4 / trigger; the same layout shifted up by 8 enables DMA |
| 2 | STAT | bit 0 update, bits 4:1 channel flags, bit 6 trigger, bits 12:9 channel overcapture |
| 3 | EVGEN | bit 0 update, bits 4:1 channel 1 to 4, bit 6 trigger; reads as 0 |
| 4 | CHMODE | bit i set puts channel i+1 in input (capture) mode |
| 5 | CNT | counter |
| 6 | PSC | prescaler ratio, pending copy |
| 7 | ARR | auto-reload limit, pending copy |
| 8..11 | CCR1..CCR4 | channel registers |

## Requirements
- R1: EVGEN always reads 0. Writing it only acts on the bits set to 1 at positions 0, 1 to 4 and 6. Writing 0 changes nothing, and so do the other bit positions.
- R2: A forced update sets CNT to 0 in up mode and in centre mode, and restarts centre counting in the upward direction. In down mode it loads CNT with the pending ARR value.
- R3: An update, forced or from a wrap, copies the pending PSC and ARR into their working copies. When the CTRL bit 3 shadow is off, ARR writes also take effect at once. A forced update also clears the prescaler phase, so with ratio P the first count step comes P+1 clocks after the forced update.
- R4: STAT bit 0 is set by a forced update and also by a counter wrap.
- R5: A forced event on an output-mode channel sets that channel's flag in STAT bits 4:1 and leaves its CCR unchanged.
- R6: A forced event on an input-mode channel copies the present CNT into its CCR and sets its flag. CCR writes are ignored in input mode.
- R7: A capture that happens while the channel flag is already set also sets that channel's overcapture bit (STAT bits 12:9). Output-mode events never set overcapture.
- R8: A forced trigger sets STAT bit 6.
- R9: Writing STAT clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. When an event sets a flag in the same cycle as a clear, the flag ends up set.
- R10: `irq` is high while any STAT flag at bits 0, 4:1 or 6 has its matching IEN bit set. `dma_req` (bit 0 update, bits 4:1 channels, bit 5 trigger) pulses for one cycle per event when IEN bit 8+position is set. A forced event and a hardware event of the same kind in one cycle give a single pulse.
- R11: While running, the counter steps once every PSC+1 clocks. Up mode wraps from ARR to 0. Down mode wraps from 0 to ARR. Centre mode runs 0 up to ARR, then down to 0, and repeats, with an update at both turning points.
- R12: An output-mode channel raises its flag on a count step taken while CNT equals its CCR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |
| dma_req | output | 6 | Per-event DMA request pulses |

## Verification
The hardest situation to reach from the ports is a collision: a flag or event from the timer itself and a software action land on the same clock edge. One such case is a forced update on the exact edge where the counter wraps. Another is a STAT clear on the edge of a compare match. The stimulus reaches these edges by stopping the counter, writing CNT one step short of the target, and then issuing the next write a known number of cycles later. That write coincides with the hardware event, and the bench checks a single DMA pulse and a surviving flag. Counting sequences are swept over several prescaler ratios and all modes, and each value is compared against an arithmetic formula.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_DW  = 16;
    localparam int TMR_AW  = 4;
    localparam int TMR_NCH = 4;

    typedef enum logic [1:0] {
        CM_UP      = 2'd0,
        CM_DOWN    = 2'd1,
        CM_CTR     = 2'd2,
        CM_CTR_ALT = 2'd3
    } cmode_e;

    localparam logic [TMR_AW-1:0] A_CTRL   = 4'd0;
    localparam logic [TMR_AW-1:0] A_IEN    = 4'd1;
    localparam logic [TMR_AW-1:0] A_STAT   = 4'd2;
    localparam logic [TMR_AW-1:0] A_EVGEN  = 4'd3;
    localparam logic [TMR_AW-1:0] A_CHMODE = 4'd4;
    localparam logic [TMR_AW-1:0] A_CNT    = 4'd5;
    localparam logic [TMR_AW-1:0] A_PSC    = 4'd6;
    localparam logic [TMR_AW-1:0] A_ARR    = 4'd7;
    localparam logic [TMR_AW-1:0] A_CCR0   = 4'd8;

    localparam int B_UPD  = 0;
    localparam int B_CH0  = 1;
    localparam int B_TRG  = 6;
    localparam int B_DMA  = 8;
    localparam int B_OVR0 = 9;

    // one bit per event source; bit order matches dma_req
    typedef struct packed {
        logic               trg;
        logic [TMR_NCH-1:0] ch;
        logic               upd;
    } evt_t;

    typedef struct packed {
        logic   arpe;
        cmode_e mode;
        logic   run;
    } ctrl_t;

    function automatic evt_t evt_decode(input logic [TMR_DW-1:0] w);
        evt_t e;
        e.upd = w[B_UPD];
        e.ch  = w[B_CH0 +: TMR_NCH];
        e.trg = w[B_TRG];
        return e;
    endfunction

    function automatic logic [TMR_DW-1:0] evt_encode(input evt_t e);
        logic [TMR_DW-1:0] w;
        w = '0;
        w[B_UPD]            = e.upd;
        w[B_CH0 +: TMR_NCH] = e.ch;
        w[B_TRG]            = e.trg;
        return w;
    endfunction

endpackage

// File: rtl/tmr_timebase.sv
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  cmode_e           mode,
    input  logic             arpe,
    input  logic             upd_force,
    input  logic             cnt_we,
    input  logic             psc_we,
    input  logic             arr_we,
    input  logic [CNT_W-1:0] reg_wd,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] arr_pend,
    output logic [CNT_W-1:0] psc_pend,
    output logic             tick,
    output logic             upd_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] pc_q, psc_act_q, psc_pre_q;
    logic [CNT_W-1:0] arr_act_q, arr_pre_q, cnt_q;
    logic             dn_q;

    logic [CNT_W-1:0] cnt_step;
    logic             dn_step;
    logic             wrap;

    assign tick     = run && (pc_q == psc_act_q);
    assign cnt      = cnt_q;
    assign arr_pend = arr_pre_q;
    assign psc_pend = psc_pre_q;
    assign upd_evt  = upd_force || (tick && wrap && !cnt_we);

    // next counter value on a count step
    always_comb begin
        cnt_step = cnt_q;
        dn_step  = dn_q;
        wrap     = 1'b0;
        case (mode)
            CM_UP: begin
                if (cnt_q >= arr_act_q) begin
                    cnt_step = '0;
                    wrap     = 1'b1;
                end else begin
                    cnt_step = cnt_q + 1'b1;
                end
            end
            CM_DOWN: begin
                if (cnt_q == '0) begin
                    cnt_step = arr_act_q;
                    wrap     = 1'b1;
                end else begin
                    cnt_step = cnt_q - 1'b1;
                end
            end
            default: begin
                if (!dn_q) begin
                    if (cnt_q >= arr_act_q) begin
                        cnt_step = (arr_act_q == '0) ? '0 : arr_act_q - 1'b1;
                        dn_step  = 1'b1;
                        wrap     = 1'b1;
                    end else begin
                        cnt_step = cnt_q + 1'b1;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        cnt_step = (arr_act_q == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
                        dn_step  = 1'b0;
                        wrap     = 1'b1;
                    end else begin
                        cnt_step = cnt_q - 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            psc_act_q <= '0;
            psc_pre_q <= '0;
            arr_act_q <= CNT_MAX;
            arr_pre_q <= CNT_MAX;
            cnt_q     <= '0;
            dn_q      <= 1'b0;
        end else begin
            if (psc_we) begin
                psc_pre_q <= reg_wd;
            end
            if (arr_we) begin
                arr_pre_q <= reg_wd;
                if (!arpe) begin
                    arr_act_q <= reg_wd;
                end
            end
            if (upd_force) begin
                pc_q      <= '0;
                psc_act_q <= psc_pre_q;
                arr_act_q <= arr_pre_q;
                dn_q      <= 1'b0;
                cnt_q     <= (mode == CM_DOWN) ? arr_pre_q : '0;
            end else begin
                if (run) begin
                    pc_q <= tick ? '0 : pc_q + 1'b1;
                end
                if (cnt_we) begin
                    cnt_q <= reg_wd;
                end else if (tick) begin
                    cnt_q <= cnt_step;
                    dn_q  <= dn_step;
                end
                if (upd_evt) begin
                    psc_act_q <= psc_pre_q;
                    arr_act_q <= arr_pre_q;
                end
            end
        end
    end

    assert_psc_clear_R3: assert property (@(posedge clk) disable iff (rst)
        upd_force |=> (pc_q == '0));

    assert_upd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (upd_force && mode != CM_DOWN) |=> (cnt_q == '0 && !dn_q));

    assert_down_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (upd_force && mode == CM_DOWN) |=> (cnt_q == $past(arr_pre_q)));

    assert_hold_between_steps_R11: assert property (@(posedge clk) disable iff (rst)
        (!upd_force && !cnt_we && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_mode,
    input  logic             force_ev,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ccr_we,
    input  logic [CNT_W-1:0] ccr_wd,
    input  logic             flag_clr,
    input  logic             ovr_clr,
    output logic [CNT_W-1:0] ccr,
    output logic             flag,
    output logic             ovr,
    output logic             ev
);

    logic [CNT_W-1:0] ccr_q;
    logic             flag_q, ovr_q;
    logic             hw_match;

    assign hw_match = !in_mode && step && (cnt == ccr_q);
    assign ev       = force_ev || hw_match;
    assign ccr      = ccr_q;
    assign flag     = flag_q;
    assign ovr      = ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q  <= '0;
            flag_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (ev && in_mode) begin
                ccr_q <= cnt;
            end else if (ccr_we && !in_mode) begin
                ccr_q <= ccr_wd;
            end

            if (ev) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end

            if (ev && in_mode && flag_q) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
        ev |=> flag_q);

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (ev && in_mode) |=> (ccr_q == $past(cnt)));

    assert_overcapture_R7: assert property (@(posedge clk) disable iff (rst)
        (ev && in_mode && flag_q) |=> ovr_q);

    assert_no_ovr_output_R7: assert property (@(posedge clk) disable iff (rst)
        (!ovr_q && !in_mode) |=> !ovr_q);

endmodule

// File: rtl/tmr_evgen_core.sv
module tmr_evgen_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [TMR_AW-1:0]   addr,
    input  logic [TMR_DW-1:0]   wdata,
    output logic [TMR_DW-1:0]   rdata,
    output logic                irq,
    output logic [TMR_NCH+1:0]  dma_req
);

    localparam int NSRC = TMR_NCH + 2;

    ctrl_t              ctrl_q;
    evt_t               irq_en_q, dma_en_q;
    logic [TMR_NCH-1:0] chmode_q;
    logic               upd_flag_q, trg_flag_q;
    logic [NSRC-1:0]    dma_q;

    logic               stat_wr;
    evt_t               frc, cur, flags;
    logic [CNT_W-1:0]   cnt, arr_pend, psc_pend;
    logic               tick, upd_evt;
    logic [TMR_NCH-1:0] ch_ev, ch_flag, ch_ovr;
    logic [CNT_W-1:0]   ccr_arr [TMR_NCH];

    assign stat_wr = wr_en && (addr == A_STAT);
    assign frc     = (wr_en && addr == A_EVGEN) ? evt_decode(wdata) : '0;

    tmr_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .mode      (ctrl_q.mode),
        .arpe      (ctrl_q.arpe),
        .upd_force (frc.upd),
        .cnt_we    (wr_en && addr == A_CNT),
        .psc_we    (wr_en && addr == A_PSC),
        .arr_we    (wr_en && addr == A_ARR),
        .reg_wd    (wdata[CNT_W-1:0]),
        .cnt       (cnt),
        .arr_pend  (arr_pend),
        .psc_pend  (psc_pend),
        .tick      (tick),
        .upd_evt   (upd_evt)
    );

    for (genvar i = 0; i < TMR_NCH; i++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .in_mode  (chmode_q[i]),
            .force_ev (frc.ch[i]),
            .step     (tick),
            .cnt      (cnt),
            .ccr_we   (wr_en && addr == (A_CCR0 + TMR_AW'(i))),
            .ccr_wd   (wdata[CNT_W-1:0]),
            .flag_clr (stat_wr && !wdata[B_CH0 + i]),
            .ovr_clr  (stat_wr && !wdata[B_OVR0 + i]),
            .ccr      (ccr_arr[i]),
            .flag     (ch_flag[i]),
            .ovr      (ch_ovr[i]),
            .ev       (ch_ev[i])
        );
    end

    always_comb begin
        cur.upd   = upd_evt;
        cur.ch    = ch_ev;
        cur.trg   = frc.trg;
        flags.upd = upd_flag_q;
        flags.ch  = ch_flag;
        flags.trg = trg_flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '{arpe: 1'b0, mode: CM_UP, run: 1'b0};
            irq_en_q   <= '0;
            dma_en_q   <= '0;
            chmode_q   <= '0;
            upd_flag_q <= 1'b0;
            trg_flag_q <= 1'b0;
            dma_q      <= '0;
        end else begin
            if (wr_en && addr == A_CTRL) begin
                ctrl_q.run  <= wdata[0];
                ctrl_q.mode <= cmode_e'(wdata[2:1]);
                ctrl_q.arpe <= wdata[3];
            end
            if (wr_en && addr == A_IEN) begin
                irq_en_q <= evt_decode(wdata);
                dma_en_q <= evt_decode(wdata >> B_DMA);
            end
            if (wr_en && addr == A_CHMODE) begin
                chmode_q <= wdata[TMR_NCH-1:0];
            end
            if (upd_evt) begin
                upd_flag_q <= 1'b1;
            end else if (stat_wr && !wdata[B_UPD]) begin
                upd_flag_q <= 1'b0;
            end
            if (frc.trg) begin
                trg_flag_q <= 1'b1;
            end else if (stat_wr && !wdata[B_TRG]) begin
                trg_flag_q <= 1'b0;
            end
            dma_q <= NSRC'(cur) & NSRC'(dma_en_q);
        end
    end

    assign irq     = |(NSRC'(flags) & NSRC'(irq_en_q));
    assign dma_req = dma_q;

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = TMR_DW'(ctrl_q);
            A_IEN:    rdata = evt_encode(irq_en_q) | (evt_encode(dma_en_q) << B_DMA);
            A_STAT: begin
                rdata = evt_encode(flags);
                rdata[B_OVR0 +: TMR_NCH] = ch_ovr;
            end
            A_EVGEN:  rdata = '0;
            A_CHMODE: rdata = TMR_DW'(chmode_q);
            A_CNT:    rdata = TMR_DW'(cnt);
            A_PSC:    rdata = TMR_DW'(psc_pend);
            A_ARR:    rdata = TMR_DW'(arr_pend);
            default: begin
                for (int i = 0; i < TMR_NCH; i++) begin
                    if (addr == (A_CCR0 + TMR_AW'(i))) begin
                        rdata = TMR_DW'(ccr_arr[i]);
                    end
                end
            end
        endcase
    end

    assert_evgen_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (addr == A_EVGEN) |-> (rdata == '0));

    assert_upd_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
        upd_evt |=> upd_flag_q);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (trg_flag_q && !(stat_wr && !wdata[B_TRG])) |=> trg_flag_q);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (trg_flag_q && irq_en_q.trg) |-> irq);

    assert_dma_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (upd_evt && dma_en_q.upd) |=> dma_req[0]);

endmodule

// File: tb/tmr_evgen_core_bench.sv
module tmr_evgen_core_bench;
    timeunit 1ns;
    timeprecision 10ps;

    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        irq;
    logic [5:0]  dma_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    tmr_evgen_core u_tmr_evgen_core (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq),
        .dma_req (dma_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called just after a falling edge; the write takes effect at the next rising edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        addr = a;
        #0.1;
        v = rdata;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int seeds [3] = '{0, 7, 200};
        wr_en = 1'b0;
        addr  = '0;
        wdata = '0;
        rst   = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(A_STAT, v);  chk("R4 reset STAT", v, 16'h0);
        rd(A_CNT, v);   chk("R11 reset CNT", v, 16'h0);
        rd(A_ARR, v);   chk("R3 reset ARR", v, 16'hFFFF);
        rd(A_EVGEN, v); chk("R1 EVGEN reads 0", v, 16'h0);
        chk("R10 reset irq", {15'd0, irq}, 16'h0);
        chk("R10 reset dma", {10'd0, dma_req}, 16'h0);

        // R1: zero and unmapped bits have no effect
        wr(A_CNT, 16'd33);
        wr(A_EVGEN, 16'h0000);
        wr(A_EVGEN, 16'hFFA0);
        rd(A_CNT, v);  chk("R1 no-op write keeps CNT", v, 16'd33);
        rd(A_STAT, v); chk("R1 no-op write keeps STAT", v, 16'h0);

        // R2: forced update in every mode from several counter values
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 3; s++) begin
                wr(A_CTRL, 16'((m << 1) | 8));
                wr(A_ARR, 16'(100 + m));
                wr(A_CNT, 16'(seeds[s]));
                wr(A_EVGEN, 16'h0001);
                rd(A_CNT, v);
                chk("R2 forced update CNT", v, (m == 1) ? 16'(100 + m) : 16'h0);
                rd(A_STAT, v);   chk("R4 forced update flag", v, 16'h0001);
                rd(A_EVGEN, v);  chk("R1 EVGEN self-clears", v, 16'h0);
                wr(A_STAT, 16'h0000);
            end
        end

        // R3: prescaler phase cleared by forced update
        wr(A_CTRL, 16'h0000);
        wr(A_PSC, 16'd3);
        wr(A_ARR, 16'd1000);
        wr(A_EVGEN, 16'h0001);
        wr(A_CTRL, 16'h0001);
        @(negedge clk);
        @(negedge clk);
        wr(A_EVGEN, 16'h0001);
        rd(A_CNT, v); chk("R3 cnt after forced update", v, 16'd0);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R3 no step before P+1 clocks", v, 16'd0);
        @(negedge clk);
        rd(A_CNT, v); chk("R3 first step at P+1 clocks", v, 16'd1);
        repeat (4) @(negedge clk);
        rd(A_CNT, v); chk("R11 second step", v, 16'd2);
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0000);

        // R3/R4/R11: shadowed limit, wrap in up mode
        wr(A_CTRL, 16'h0008);
        wr(A_PSC, 16'd0);
        wr(A_ARR, 16'd5);
        wr(A_EVGEN, 16'h0001);
        wr(A_ARR, 16'd9);
        wr(A_CNT, 16'd4);
        wr(A_STAT, 16'h0000);
        wr(A_CTRL, 16'h0009);
        rd(A_CNT, v); chk("R11 up start", v, 16'd4);
        @(negedge clk);
        rd(A_CNT, v); chk("R3 old limit still active", v, 16'd5);
        @(negedge clk);
        rd(A_CNT, v);  chk("R11 up wrap to 0", v, 16'd0);
        rd(A_STAT, v); chk("R4 hardware wrap flag", v, 16'h0001);
        repeat (9) @(negedge clk);
        rd(A_CNT, v); chk("R3 new limit after wrap", v, 16'd9);
        @(negedge clk);
        rd(A_CNT, v); chk("R11 wrap at new limit", v, 16'd0);
        wr(A_CTRL, 16'h0000);

        // R11: down counting over several prescaler ratios
        for (int p = 0; p < 3; p++) begin
            wr(A_CTRL, 16'h000A);
            wr(A_PSC, 16'(p));
            wr(A_ARR, 16'd9);
            wr(A_EVGEN, 16'h0001);
            wr(A_CTRL, 16'h000B);
            for (int k = 0; k < 13; k++) begin
                rd(A_CNT, v);
                chk("R11 down sequence", v, 16'(9 - ((k / (p + 1)) % 10)));
                @(negedge clk);
            end
        end
        wr(A_CTRL, 16'h0000);

        // R11/R2: centre mode restarts upward after forced update
        wr(A_CTRL, 16'h000C);
        wr(A_PSC, 16'd0);
        wr(A_ARR, 16'd4);
        wr(A_EVGEN, 16'h0001);
        wr(A_CTRL, 16'h000D);
        for (int k = 0; k < 18; k++) begin
            rd(A_CNT, v);
            chk("R11 centre sequence", v, ((k % 8) <= 4) ? 16'(k % 8) : 16'(8 - (k % 8)));
            @(negedge clk);
        end
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0000);

        // R5/R6/R7: forced channel events, every channel, both modes
        for (int c = 0; c < 4; c++) begin
            for (int im = 0; im < 2; im++) begin
                wr(A_CHMODE, 16'h0000);
                wr(4'(8 + c), 16'(1000 + c));
                wr(A_CHMODE, 16'(im << c));
                wr(A_CNT, 16'(50 + 10 * c + im));
                wr(A_STAT, 16'h0000);
                if (im == 1) wr(4'(8 + c), 16'd7);
                wr(A_EVGEN, 16'(1 << (c + 1)));
                rd(4'(8 + c), v);
                chk(im ? "R6 capture" : "R5 output keeps CCR", v,
                    im ? 16'(50 + 10 * c + im) : 16'(1000 + c));
                rd(A_STAT, v);
                chk("R5 channel flag", v, 16'(1 << (c + 1)));
                wr(A_CNT, 16'(300 + c));
                wr(A_EVGEN, 16'(1 << (c + 1)));
                rd(4'(8 + c), v);
                chk(im ? "R6 second capture" : "R5 output keeps CCR again", v,
                    im ? 16'(300 + c) : 16'(1000 + c));
                rd(A_STAT, v);
                chk("R7 overcapture", v, 16'((1 << (c + 1)) | (im << (9 + c))));
            end
        end

        // R8, R9
        wr(A_STAT, 16'h0000);
        wr(A_EVGEN, 16'h0040);
        rd(A_STAT, v); chk("R8 trigger flag", v, 16'h0040);
        wr(A_EVGEN, 16'h0002);
        wr(A_STAT, 16'hFFFF);
        rd(A_STAT, v); chk("R9 writing ones keeps flags", v, 16'h0042);
        wr(A_STAT, 16'h0040);
        rd(A_STAT, v); chk("R9 zero clears selected flag", v, 16'h0040);

        // R10: interrupt gating
        wr(A_IEN, 16'h0002);
        chk("R10 irq masked", {15'd0, irq}, 16'h0);
        wr(A_IEN, 16'h0040);
        chk("R10 irq enabled", {15'd0, irq}, 16'h1);
        wr(A_STAT, 16'h0000);
        chk("R10 irq drops with flag", {15'd0, irq}, 16'h0);

        // R10: DMA pulse gating
        wr(A_IEN, 16'h0200);
        wr(A_EVGEN, 16'h0002);
        chk("R10 dma pulse ch1", {10'd0, dma_req}, 16'h0002);
        @(negedge clk);
        chk("R10 dma pulse one cycle", {10'd0, dma_req}, 16'h0000);
        wr(A_EVGEN, 16'h0004);
        chk("R10 dma masked ch2", {10'd0, dma_req}, 16'h0000);

        // R10/R4: forced update on the wrap edge gives one event
        wr(A_STAT, 16'h0000);
        wr(A_IEN, 16'h0100);
        wr(A_CTRL, 16'h0008);
        wr(A_PSC, 16'd0);
        wr(A_ARR, 16'd5);
        wr(A_EVGEN, 16'h0001);
        wr(A_STAT, 16'h0000);
        wr(A_CTRL, 16'h0009);
        wr(A_CNT, 16'd5);
        wr(A_EVGEN, 16'h0001);
        chk("R10 merged update dma", {10'd0, dma_req}, 16'h0001);
        rd(A_CNT, v);  chk("R2 merged update cnt", v, 16'd0);
        rd(A_STAT, v); chk("R4 merged update flag", v, 16'h0001);
        @(negedge clk);
        chk("R10 merged single pulse", {10'd0, dma_req}, 16'h0000);
        rd(A_CNT, v);  chk("R11 step after merge", v, 16'd1);
        wr(A_CTRL, 16'h0000);

        // R12/R9: compare match on the same edge as a clear
        wr(A_IEN, 16'h0000);
        wr(A_CHMODE, 16'h0000);
        wr(A_CCR0, 16'd5);
        wr(A_ARR, 16'd20);
        wr(A_STAT, 16'h0000);
        wr(A_CTRL, 16'h0001);
        wr(A_CNT, 16'd3);
        @(negedge clk);
        @(negedge clk);
        rd(A_CNT, v);  chk("R11 approach compare", v, 16'd5);
        rd(A_STAT, v); chk("R12 no flag before step", v, 16'h0000);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v); chk("R12 R9 set wins over clear", v, 16'h0002);
        wr(A_CTRL, 16'h0000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule